// File: doc/BRIEF.md
# Link Equalization Phase Controller

This block sequences transmitter equalization for one end of a high-speed serial link. After a start request it moves through four phases in a fixed order. In phase 0 it announces a starting preset and loads that preset's coefficient pair into the local transmitter. In phase 1 it waits for the receiver to report coarse lock at that preset. In phase 2 the local receiver tunes the partner's transmitter through request, apply and echo sub-loops. In phase 3 the partner tunes the local transmitter in the same way, and this end checks each request for legality and echoes it back.

Each sub-loop has four steps. A receiver evaluation arrives with a merit value and, when it fails, a requested (pre, post) pair. The controller sends that pair to the partner and waits for the partner's echo. Only an echo that matches the request and is not flagged as rejected updates the recorded partner setting. Phases 2 and 3 are each bounded by a count of external ticks. If phase 2 times out, the controller reports failure and falls back to the best pair it has evaluated. A port that is content with its presets can skip both tuning phases.

Top module: `eq_phase_ctrl`

## Requirements
- R1: After reset `phase` is 0, `done`, `fail`, `preset_valid`, `req_valid` and `echo_valid` are 0, and `tx_pre`/`tx_post` are 0/0.
- R2: A `start` in idle, done or fail state with `init_preset` in 0..9 causes `preset_valid` to be high for exactly one cycle after the next edge, with `preset_out` equal to the index. In that same cycle `tx_pre`/`tx_post` and `tune_pre`/`tune_post` take the preset pair. The table of pairs (pre/post) is: 0→0/6, 1→0/4, 2→0/5, 3→0/3, 4→0/0, 5→2/0, 6→3/0, 7→4/6, 8→5/5, 9→4/0. `phase` becomes 1 one edge later.
- R3: A `start` with `init_preset` in 10..15 moves straight to failure: `fail` is 1 after the edge, `phase` is 0, and `tx_pre`/`tx_post` are unchanged.
- R4: In phase 1 the controller waits with `phase` at 1 until `lock_ok`. At that edge it enters phase 2, or, when `skip_tune` is 1, it finishes with `done` at 1 and `phase` still 1.
- R5: In phase 2 a failing evaluation (`eval_valid` with `eval_pass` at 0) produces a one-cycle `req_valid` after the edge, carrying `eval_pre`/`eval_post`. The next `echo_in_valid` updates `tune_pre`/`tune_post` to the echoed pair only if `echo_in_rej` is 0 and the pair equals the request. Otherwise the tune pair is kept.
- R6: In phase 2 a passing evaluation enters phase 3 at that edge and keeps the tune pair.
- R7: Each phase 2 evaluation rates the current tune pair by `eval_fom`. The best pair is the first one with the strictly highest merit; it starts as the preset pair with merit 0. After `TMO_TICKS` ticks counted from phase 2 entry, the next edge sets `fail` with `phase` at 2 and loads `tune_pre`/`tune_post` with the best pair.
- R8: A phase 3 request with `part_done` at 0 produces a one-cycle `echo_valid`. The pair is legal when pre ≤ FS/3, post ≤ FS/2 and pre+post ≤ FS/2 (8, 12, 12 for FS = 24). A legal pair is applied to `tx_pre`/`tx_post` and echoed with `echo_rej` at 0. An illegal pair leaves the transmitter unchanged, and the echo carries the current transmitter pair with `echo_rej` at 1.
- R9: A phase 3 request with `part_done` at 1 ends the procedure: `done` is 1 and `phase` is 3.
- R10: After `TMO_TICKS` ticks counted from phase 3 entry, the next edge sets `fail` with `phase` at 3 and the transmitter pair unchanged.
- R11: `phase` only advances by one or returns to 0 on a new start, and `done` and `fail` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new equalization run (idle, done or fail only) |
| skip_tune | input | 1 | Finish after coarse lock, skipping both tuning phases |
| init_preset | input | 4 | Starting preset index |
| tick | input | 1 | Time-base strobe counted against the tuning timeout |
| lock_ok | input | 1 | Coarse error-rate lock reached at the preset |
| eval_valid | input | 1 | Local receiver evaluation available (phase 2) |
| eval_pass | input | 1 | Evaluation meets the fine error-rate target |
| eval_fom | input | FW | Merit of the setting under evaluation |
| eval_pre | input | CW | Pre-cursor to request when the evaluation fails |
| eval_post | input | CW | Post-cursor to request when the evaluation fails |
| echo_in_valid | input | 1 | Partner echo of an applied request |
| echo_in_rej | input | 1 | Partner rejected the request |
| echo_in_pre | input | CW | Echoed pre-cursor |
| echo_in_post | input | CW | Echoed post-cursor |
| part_valid | input | 1 | Partner request for the local transmitter (phase 3) |
| part_done | input | 1 | Partner accepts the current local setting |
| part_pre | input | CW | Requested pre-cursor |
| part_post | input | CW | Requested post-cursor |
| preset_valid | output | 1 | Preset announcement strobe |
| preset_out | output | 4 | Announced preset index |
| tx_pre | output | CW | Pre-cursor applied to the local transmitter |
| tx_post | output | CW | Post-cursor applied to the local transmitter |
| echo_valid | output | 1 | Echo strobe toward the partner |
| echo_rej | output | 1 | Echoed request was rejected |
| echo_pre | output | CW | Echoed pre-cursor |
| echo_post | output | CW | Echoed post-cursor |
| req_valid | output | 1 | Request strobe toward the partner |
| req_pre | output | CW | Requested partner pre-cursor |
| req_post | output | CW | Requested partner post-cursor |
| tune_pre | output | CW | Confirmed (or fallback) partner pre-cursor |
| tune_post | output | CW | Confirmed (or fallback) partner post-cursor |
| phase | output | 2 | Current or last reached phase |
| done | output | 1 | Equalization finished |
| fail | output | 1 | Equalization failed |

## Verification
The hardest case to reach is the phase 2 timeout fallback. It needs a run of several sub-loops in which merit and confirmation diverge. The pair with the highest merit must not be the one last confirmed, so the fallback visibly moves `tune_pre`/`tune_post` back to an earlier setting. The stimulus confirms two settings, gives the first evaluated one the higher merit, and then holds `tick` high. It samples one edge before and one edge after the tick budget is spent. Phase 3 legality is walked through a vector table that crosses each limit (pre, post and the diagonal sum) by one step from both sides.

// File: rtl/eq_pkg.sv
`timescale 1ns/1ps
package eq_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_SEND,
      S_LOCK,
      S_EVAL,
      S_ECHO,
      S_PART,
      S_DONE,
      S_FAIL
   } eq_state_e;

   localparam int unsigned NUM_PRESETS = 10;
   localparam int unsigned PRESET_W    = 4;
endpackage

// File: rtl/eq_preset_map.sv
`timescale 1ns/1ps
module eq_preset_map #(
   parameter int unsigned CW = 5
) (
   input  logic [eq_pkg::PRESET_W-1:0] idx,
   output logic [CW-1:0]               pre,
   output logic [CW-1:0]               post,
   output logic                        known
);
   always_comb begin
      known = (32'(idx) < eq_pkg::NUM_PRESETS);
      pre   = '0;
      post  = '0;
      case (idx)
         4'd0:    begin pre = CW'(0); post = CW'(6); end
         4'd1:    begin pre = CW'(0); post = CW'(4); end
         4'd2:    begin pre = CW'(0); post = CW'(5); end
         4'd3:    begin pre = CW'(0); post = CW'(3); end
         4'd4:    begin pre = CW'(0); post = CW'(0); end
         4'd5:    begin pre = CW'(2); post = CW'(0); end
         4'd6:    begin pre = CW'(3); post = CW'(0); end
         4'd7:    begin pre = CW'(4); post = CW'(6); end
         4'd8:    begin pre = CW'(5); post = CW'(5); end
         4'd9:    begin pre = CW'(4); post = CW'(0); end
         default: begin pre = '0;     post = '0;     end
      endcase
   end
endmodule

// File: rtl/eq_coef_check.sv
`timescale 1ns/1ps
module eq_coef_check #(
   parameter int unsigned CW          = 5,
   parameter int unsigned FS          = 24,
   parameter bit          CHECK_BOOST = 1'b1
) (
   input  logic [CW-1:0] pre,
   input  logic [CW-1:0] post,
   output logic          legal
);
   localparam logic [CW:0] PRE_LIM   = (CW+1)'(FS / 3);
   localparam logic [CW:0] POST_LIM  = (CW+1)'(FS / 2);
   localparam logic [CW:0] BOOST_LIM = (CW+1)'(FS / 2);

   logic [CW:0] sum;
   logic        box_ok;

   assign sum    = {1'b0, pre} + {1'b0, post};
   assign box_ok = ({1'b0, pre} <= PRE_LIM) && ({1'b0, post} <= POST_LIM);

   generate
      if (CHECK_BOOST) begin : g_boost
         assign legal = box_ok && (sum <= BOOST_LIM);
      end else begin : g_box
         assign legal = box_ok;
      end
   endgenerate
endmodule

// File: rtl/eq_tick_timer.sv
`timescale 1ns/1ps
module eq_tick_timer #(
   parameter int unsigned LIMIT = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic tick,
   output logic expired
);
   localparam int unsigned TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt_q;

   assign expired = (cnt_q == TW'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && tick && !expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TW'(LIMIT));
endmodule

// File: rtl/eq_phase_ctrl.sv
`timescale 1ns/1ps
module eq_phase_ctrl #(
   parameter int unsigned CW          = 5,
   parameter int unsigned FS          = 24,
   parameter int unsigned FW          = 8,
   parameter int unsigned TMO_TICKS   = 24,
   parameter bit          CHECK_BOOST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          skip_tune,
   input  logic [3:0]    init_preset,
   input  logic          tick,
   input  logic          lock_ok,
   input  logic          eval_valid,
   input  logic          eval_pass,
   input  logic [FW-1:0] eval_fom,
   input  logic [CW-1:0] eval_pre,
   input  logic [CW-1:0] eval_post,
   input  logic          echo_in_valid,
   input  logic          echo_in_rej,
   input  logic [CW-1:0] echo_in_pre,
   input  logic [CW-1:0] echo_in_post,
   input  logic          part_valid,
   input  logic          part_done,
   input  logic [CW-1:0] part_pre,
   input  logic [CW-1:0] part_post,
   output logic          preset_valid,
   output logic [3:0]    preset_out,
   output logic [CW-1:0] tx_pre,
   output logic [CW-1:0] tx_post,
   output logic          echo_valid,
   output logic          echo_rej,
   output logic [CW-1:0] echo_pre,
   output logic [CW-1:0] echo_post,
   output logic          req_valid,
   output logic [CW-1:0] req_pre,
   output logic [CW-1:0] req_post,
   output logic [CW-1:0] tune_pre,
   output logic [CW-1:0] tune_post,
   output logic [1:0]    phase,
   output logic          done,
   output logic          fail
);
   import eq_pkg::*;

   generate
      if (FS < 20) begin : g_bad_fs
         $error("eq_phase_ctrl: FS must be at least 20 so that every preset is legal");
      end
      if ((1 << CW) <= FS) begin : g_bad_cw
         $error("eq_phase_ctrl: CW too narrow for FS");
      end
      if (TMO_TICKS < 1) begin : g_bad_tmo
         $error("eq_phase_ctrl: TMO_TICKS must be positive");
      end
      if (FW < 1) begin : g_bad_fw
         $error("eq_phase_ctrl: FW must be positive");
      end
   endgenerate

   eq_state_e     st_q, st_d;
   logic [1:0]    phase_q;
   logic [3:0]    preset_q;
   logic [CW-1:0] tx_pre_q, tx_post_q;
   logic [CW-1:0] tune_pre_q, tune_post_q;
   logic [CW-1:0] best_pre_q, best_post_q;
   logic [FW-1:0] best_fom_q;
   logic [CW-1:0] req_pre_q, req_post_q;
   logic [CW-1:0] ech_pre_q, ech_post_q;
   logic          req_vld_q, ech_vld_q, ech_rej_q;

   logic [CW-1:0] ps_pre, ps_post;
   logic          ps_known;
   logic          part_legal, tx_legal;
   logic          tmr_run, tmr_clr, expired;
   logic          idle_like;

   eq_preset_map #(.CW(CW)) u_preset (
      .idx   (init_preset),
      .pre   (ps_pre),
      .post  (ps_post),
      .known (ps_known)
   );

   eq_coef_check #(.CW(CW), .FS(FS), .CHECK_BOOST(CHECK_BOOST)) u_part_chk (
      .pre   (part_pre),
      .post  (part_post),
      .legal (part_legal)
   );

   eq_coef_check #(.CW(CW), .FS(FS), .CHECK_BOOST(CHECK_BOOST)) u_tx_chk (
      .pre   (tx_pre_q),
      .post  (tx_post_q),
      .legal (tx_legal)
   );

   assign tmr_run = (st_q == S_EVAL) || (st_q == S_ECHO) || (st_q == S_PART);
   assign tmr_clr = !tmr_run || ((st_d == S_PART) && (st_q != S_PART));

   eq_tick_timer #(.LIMIT(TMO_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .run     (tmr_run),
      .tick    (tick),
      .expired (expired)
   );

   assign idle_like = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_FAIL);

   always_comb begin
      st_d = st_q;
      case (st_q)
         S_IDLE, S_DONE, S_FAIL: begin
            if (start) st_d = ps_known ? S_SEND : S_FAIL;
         end
         S_SEND: st_d = S_LOCK;
         S_LOCK: begin
            if (lock_ok) st_d = skip_tune ? S_DONE : S_EVAL;
         end
         S_EVAL: begin
            if (expired)         st_d = S_FAIL;
            else if (eval_valid) st_d = eval_pass ? S_PART : S_ECHO;
         end
         S_ECHO: begin
            if (expired)            st_d = S_FAIL;
            else if (echo_in_valid) st_d = S_EVAL;
         end
         S_PART: begin
            if (expired)                      st_d = S_FAIL;
            else if (part_valid && part_done) st_d = S_DONE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         phase_q     <= 2'd0;
         preset_q    <= 4'd0;
         tx_pre_q    <= '0;
         tx_post_q   <= '0;
         tune_pre_q  <= '0;
         tune_post_q <= '0;
         best_pre_q  <= '0;
         best_post_q <= '0;
         best_fom_q  <= '0;
         req_pre_q   <= '0;
         req_post_q  <= '0;
         ech_pre_q   <= '0;
         ech_post_q  <= '0;
         req_vld_q   <= 1'b0;
         ech_vld_q   <= 1'b0;
         ech_rej_q   <= 1'b0;
      end else begin
         st_q      <= st_d;
         req_vld_q <= 1'b0;
         ech_vld_q <= 1'b0;
         if (idle_like) begin
            if (start) begin
               phase_q <= 2'd0;
               if (ps_known) begin
                  preset_q    <= init_preset;
                  tx_pre_q    <= ps_pre;
                  tx_post_q   <= ps_post;
                  tune_pre_q  <= ps_pre;
                  tune_post_q <= ps_post;
                  best_pre_q  <= ps_pre;
                  best_post_q <= ps_post;
                  best_fom_q  <= '0;
               end
            end
         end else begin
            case (st_q)
               S_SEND: phase_q <= 2'd1;
               S_LOCK: begin
                  if (lock_ok && !skip_tune) phase_q <= 2'd2;
               end
               S_EVAL: begin
                  if (expired) begin
                     tune_pre_q  <= best_pre_q;
                     tune_post_q <= best_post_q;
                  end else if (eval_valid) begin
                     if (eval_fom > best_fom_q) begin
                        best_fom_q  <= eval_fom;
                        best_pre_q  <= tune_pre_q;
                        best_post_q <= tune_post_q;
                     end
                     if (eval_pass) begin
                        phase_q <= 2'd3;
                     end else begin
                        req_vld_q  <= 1'b1;
                        req_pre_q  <= eval_pre;
                        req_post_q <= eval_post;
                     end
                  end
               end
               S_ECHO: begin
                  if (expired) begin
                     tune_pre_q  <= best_pre_q;
                     tune_post_q <= best_post_q;
                  end else if (echo_in_valid && !echo_in_rej &&
                               (echo_in_pre == req_pre_q) && (echo_in_post == req_post_q)) begin
                     tune_pre_q  <= echo_in_pre;
                     tune_post_q <= echo_in_post;
                  end
               end
               S_PART: begin
                  if (!expired && part_valid && !part_done) begin
                     ech_vld_q <= 1'b1;
                     if (part_legal) begin
                        tx_pre_q   <= part_pre;
                        tx_post_q  <= part_post;
                        ech_pre_q  <= part_pre;
                        ech_post_q <= part_post;
                        ech_rej_q  <= 1'b0;
                     end else begin
                        ech_pre_q  <= tx_pre_q;
                        ech_post_q <= tx_post_q;
                        ech_rej_q  <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign preset_valid = (st_q == S_SEND);
   assign preset_out   = preset_q;
   assign tx_pre       = tx_pre_q;
   assign tx_post      = tx_post_q;
   assign echo_valid   = ech_vld_q;
   assign echo_rej     = ech_rej_q;
   assign echo_pre     = ech_pre_q;
   assign echo_post    = ech_post_q;
   assign req_valid    = req_vld_q;
   assign req_pre      = req_pre_q;
   assign req_post     = req_post_q;
   assign tune_pre     = tune_pre_q;
   assign tune_post    = tune_post_q;
   assign phase        = phase_q;
   assign done         = (st_q == S_DONE);
   assign fail         = (st_q == S_FAIL);

   p_preset_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      preset_valid |=> (!preset_valid && (phase == 2'd1)));

   p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   p_p2_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (((st_q == S_EVAL) || (st_q == S_ECHO)) && expired) |=>
         (fail && (tune_pre == $past(best_pre_q)) && (tune_post == $past(best_post_q))));

   p_reject_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_PART) && !expired && part_valid && !part_done && !part_legal) |=>
         ($stable(tx_pre_q) && $stable(tx_post_q) && echo_valid && echo_rej));

   p_tx_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_legal);

   p_p3_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_PART) && expired) |=> (fail && $stable(tx_pre_q) && $stable(tx_post_q)));

   p_phase_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> ((phase == $past(phase) + 2'd1) || (phase == 2'd0)));

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
endmodule

// File: tb/test_eq_phase_ctrl.sv
`timescale 1ns/1ps
module test_eq_phase_ctrl;
   localparam int CW = 5;
   localparam int FW = 8;
   localparam int TMO = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, skip_tune = 1'b0, tick = 1'b0, lock_ok = 1'b0;
   logic [3:0]    init_preset = 4'd0;
   logic          eval_valid = 1'b0, eval_pass = 1'b0;
   logic [FW-1:0] eval_fom = '0;
   logic [CW-1:0] eval_pre = '0, eval_post = '0;
   logic          echo_in_valid = 1'b0, echo_in_rej = 1'b0;
   logic [CW-1:0] echo_in_pre = '0, echo_in_post = '0;
   logic          part_valid = 1'b0, part_done = 1'b0;
   logic [CW-1:0] part_pre = '0, part_post = '0;
   logic          preset_valid, echo_valid, echo_rej, req_valid, done, fail;
   logic [3:0]    preset_out;
   logic [CW-1:0] tx_pre, tx_post, echo_pre, echo_post, req_pre, req_post, tune_pre, tune_post;
   logic [1:0]    phase;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   eq_phase_ctrl #(.CW(CW), .FS(24), .FW(FW), .TMO_TICKS(TMO)) i_eq_phase_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .skip_tune(skip_tune),
      .init_preset(init_preset), .tick(tick), .lock_ok(lock_ok),
      .eval_valid(eval_valid), .eval_pass(eval_pass), .eval_fom(eval_fom),
      .eval_pre(eval_pre), .eval_post(eval_post),
      .echo_in_valid(echo_in_valid), .echo_in_rej(echo_in_rej),
      .echo_in_pre(echo_in_pre), .echo_in_post(echo_in_post),
      .part_valid(part_valid), .part_done(part_done),
      .part_pre(part_pre), .part_post(part_post),
      .preset_valid(preset_valid), .preset_out(preset_out),
      .tx_pre(tx_pre), .tx_post(tx_post),
      .echo_valid(echo_valid), .echo_rej(echo_rej),
      .echo_pre(echo_pre), .echo_post(echo_post),
      .req_valid(req_valid), .req_pre(req_pre), .req_post(req_post),
      .tune_pre(tune_pre), .tune_post(tune_post),
      .phase(phase), .done(done), .fail(fail)
   );

   // phase 3 request table: {pre, post, exp_rej, exp_tx_pre, exp_tx_post}
   localparam int NV = 8;
   localparam logic [20:0] P3_VEC [NV] = '{
      {5'd2, 5'd8,  1'b0, 5'd2, 5'd8},
      {5'd9, 5'd0,  1'b1, 5'd2, 5'd8},
      {5'd8, 5'd4,  1'b0, 5'd8, 5'd4},
      {5'd0, 5'd13, 1'b1, 5'd8, 5'd4},
      {5'd7, 5'd6,  1'b1, 5'd8, 5'd4},
      {5'd0, 5'd12, 1'b0, 5'd0, 5'd12},
      {5'd6, 5'd6,  1'b0, 5'd6, 5'd6},
      {5'd3, 5'd3,  1'b0, 5'd3, 5'd3}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_start(input logic [3:0] p, input logic skip);
      start = 1'b1; init_preset = p; skip_tune = skip;
      step();
      start = 1'b0;
   endtask

   task automatic do_lock();
      lock_ok = 1'b1;
      step();
      lock_ok = 1'b0;
   endtask

   task automatic do_eval(input logic pass, input int fom, input int pr, input int po);
      eval_valid = 1'b1; eval_pass = pass; eval_fom = FW'(fom);
      eval_pre = CW'(pr); eval_post = CW'(po);
      step();
      eval_valid = 1'b0;
   endtask

   task automatic do_echo(input logic rej, input int pr, input int po);
      echo_in_valid = 1'b1; echo_in_rej = rej;
      echo_in_pre = CW'(pr); echo_in_post = CW'(po);
      step();
      echo_in_valid = 1'b0;
   endtask

   task automatic do_part(input logic dn, input int pr, input int po);
      part_valid = 1'b1; part_done = dn; part_pre = CW'(pr); part_post = CW'(po);
      step();
      part_valid = 1'b0; part_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 phase", phase, 0);
      check("R1 done", done, 0);
      check("R1 fail", fail, 0);
      check("R1 strobes", {preset_valid, req_valid, echo_valid}, 0);
      check("R1 tx", {tx_pre, tx_post}, 0);

      // R2 phase 0 with preset 7
      do_start(4'd7, 1'b0);
      check("R2 preset_valid", preset_valid, 1);
      check("R2 preset_out", preset_out, 7);
      check("R2 tx", {tx_pre, tx_post}, {5'd4, 5'd6});
      check("R2 tune", {tune_pre, tune_post}, {5'd4, 5'd6});
      check("R2 phase0", phase, 0);
      step();
      check("R2 pulse end", preset_valid, 0);
      check("R2 phase1", phase, 1);

      // R4 wait for lock
      step(); step(); step();
      check("R4 wait", phase, 1);
      do_lock();
      check("R4 phase2", phase, 2);

      // R5 sub-loops
      do_eval(1'b0, 10, 5, 5);
      check("R5 req_valid", req_valid, 1);
      check("R5 req pair", {req_pre, req_post}, {5'd5, 5'd5});
      step();
      check("R5 req pulse end", req_valid, 0);
      do_echo(1'b0, 5, 5);
      check("R5 echo accept", {tune_pre, tune_post}, {5'd5, 5'd5});
      do_eval(1'b0, 30, 6, 5);
      do_echo(1'b1, 6, 5);
      check("R5 echo reject", {tune_pre, tune_post}, {5'd5, 5'd5});
      do_eval(1'b0, 20, 6, 4);
      do_echo(1'b0, 6, 3);
      check("R5 echo mismatch", {tune_pre, tune_post}, {5'd5, 5'd5});
      do_eval(1'b0, 20, 7, 4);
      do_echo(1'b0, 7, 4);
      check("R5 echo accept 2", {tune_pre, tune_post}, {5'd7, 5'd4});

      // R6 pass
      do_eval(1'b1, 40, 0, 0);
      check("R6 phase3", phase, 3);
      check("R6 tune kept", {tune_pre, tune_post}, {5'd7, 5'd4});
      check("R6 tx kept", {tx_pre, tx_post}, {5'd4, 5'd6});

      // R8 phase 3 legality table
      for (int i = 0; i < NV; i++) begin
         do_part(1'b0, int'(P3_VEC[i][20:16]), int'(P3_VEC[i][15:11]));
         check($sformatf("R8 vec%0d echo_valid", i), echo_valid, 1);
         check($sformatf("R8 vec%0d echo_rej", i), echo_rej, int'(P3_VEC[i][10]));
         check($sformatf("R8 vec%0d echo pair", i), {echo_pre, echo_post}, int'(P3_VEC[i][9:0]));
         check($sformatf("R8 vec%0d tx", i), {tx_pre, tx_post}, int'(P3_VEC[i][9:0]));
      end
      step();
      check("R8 echo pulse end", echo_valid, 0);

      // R9 partner done
      do_part(1'b1, 0, 0);
      check("R9 done", done, 1);
      check("R9 phase", phase, 3);
      check("R11 exclusive", done & fail, 0);

      // R3 illegal preset index
      do_start(4'd12, 1'b0);
      check("R3 fail", fail, 1);
      check("R3 phase", phase, 0);
      check("R3 tx kept", {tx_pre, tx_post}, {5'd3, 5'd3});
      check("R3 no announce", preset_valid, 0);

      // R4 skip tuning
      do_start(4'd8, 1'b1);
      check("R2 preset8 tx", {tx_pre, tx_post}, {5'd5, 5'd5});
      step();
      do_lock();
      check("R4 skip done", done, 1);
      check("R4 skip phase", phase, 1);

      // R7 phase 2 timeout with best-pair fallback
      do_start(4'd0, 1'b0);
      step();
      do_lock();
      check("R7 phase2", phase, 2);
      do_eval(1'b0, 5, 1, 1);
      do_echo(1'b0, 1, 1);
      do_eval(1'b0, 3, 2, 2);
      do_echo(1'b0, 2, 2);
      check("R7 tune before", {tune_pre, tune_post}, {5'd2, 5'd2});
      tick = 1'b1;
      repeat (TMO) step();
      check("R7 not yet", fail, 0);
      step();
      tick = 1'b0;
      check("R7 fail", fail, 1);
      check("R7 phase", phase, 2);
      check("R7 best pair", {tune_pre, tune_post}, {5'd0, 5'd6});
      check("R11 exclusive 2", done & fail, 0);

      // R10 phase 3 timeout
      do_start(4'd4, 1'b0);
      step();
      do_lock();
      do_eval(1'b1, 1, 0, 0);
      check("R10 phase3", phase, 3);
      do_part(1'b0, 3, 2);
      check("R10 tx applied", {tx_pre, tx_post}, {5'd3, 5'd2});
      tick = 1'b1;
      repeat (TMO) step();
      check("R10 not yet", fail, 0);
      step();
      tick = 1'b0;
      check("R10 fail", fail, 1);
      check("R10 phase", phase, 3);
      check("R10 tx kept", {tx_pre, tx_post}, {5'd3, 5'd2});

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule